// File: doc/BRIEF.md
# Sampling Converter Serial Output Port

This block is the digital back end of a 16-bit sampling converter. It runs on a fast system clock and watches three slow pins from the host: a conversion-start strobe, a serial clock and a serial data input. A rising edge on the start strobe begins a conversion. The conversion has a fixed length, counted in system-clock cycles. When it ends, the parallel result from the conversion core is captured and sent out on a serial data pin, most significant bit first. A separate output enable lets a pad drive that pin or float it.

The block chooses how it behaves at every conversion start, from the pin levels at that moment. In select mode, the start strobe or the serial data input acts as the frame enable. In daisy-chain mode, the serial data input is fed into the block's own shift register, so that results from devices further up the chain flow through it. In each mode a leading busy bit can be enabled. This bit tells the host that the conversion has finished.

All three pins pass through two-flop synchronizers. Edges are detected on the synchronized copies, so the serial clock must run slower than a quarter of the system clock.

Top module: `ser_adc_port`

## Requirements
- R1: A rising edge on `conv_start` starts a conversion and latches the mode from the synchronized `ser_din` level. High selects select mode and low selects chain mode. The mode then stays fixed until the next accepted start.
- R2: In chain mode, the leading busy bit is enabled when `ser_clk` is high at the accepted start and disabled when it is low.
- R3: In select mode, if `conv_start` or `ser_din` is low when the conversion ends, the port drives a 0 start bit. The first `ser_clk` falling edge then brings the MSB, and the frame ends after the 17th falling edge.
- R4: After a start is accepted, `busy` stays high for exactly CONV_CYC system-clock cycles. Further `conv_start` rising edges during that time have no effect. In select mode `ser_dout_oe` is low during the conversion.
- R5: In select mode without the busy bit, the MSB is driven when the enable goes low: `conv_start` low with `ser_din` high, or `ser_din` low with `conv_start` high. Each `ser_clk` falling edge then presents the next lower bit.
- R6: In select mode, `ser_dout_oe` drops when both `conv_start` and `ser_din` are high, or after the 16th falling edge (the 17th with the busy bit). It stays low until the next conversion.
- R7: In chain mode during a conversion, the port drives 0 whenever `ser_din` and `conv_start` are both low. Without the busy bit it drives the MSB as soon as the conversion ends.
- R8: In chain mode, each `ser_clk` falling edge shifts `ser_din` into the low end of the shift register. A bit captured on one falling edge is on `ser_dout` after the 15th following falling edge, so the output is the local 16-bit word followed by the upstream word.
- R9: In chain mode with the busy bit, after the conversion ends `ser_dout` follows `ser_din` (driven, high once upstream is high) until the first `ser_clk` falling edge. After that edge the MSB is shown.
- R10: `conv_result` is captured as straight binary in the cycle the conversion ends. Later changes on it do not alter the frame being sent.
- R11: `ser_clk` falling edges during a conversion neither shift data nor count toward the frame length.
- R12: While `rst` is high, `busy`, `ser_dout` and `ser_dout_oe` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Asynchronous conversion strobe; its rising edge starts a conversion and serves as the low-active frame enable in select mode |
| ser_clk | input | 1 | Asynchronous serial clock from the host; data moves on its falling edge |
| ser_din | input | 1 | Asynchronous serial input: mode choice at start, frame enable in select mode, upstream data in chain mode |
| conv_result | input | DATA_W | Parallel straight-binary result from the conversion core |
| ser_dout | output | 1 | Registered serial data output |
| ser_dout_oe | output | 1 | Registered output enable for the pad tri-state |
| busy | output | 1 | High while a conversion is in progress |

## Verification
Some properties are checked on every cycle. While converting, the latched mode and the conversion length hold steady, and start strobes in that window do nothing. Each shift moves the register up by one place and takes in the serial input. The busy start bit is used up without moving the data. Select mode never counts past its frame limit, and the output is quiet once a frame ends.

Other behaviour can only be seen from the bench. These are the exact bit order of whole frames in the five pin set-ups, the 16-edge delay of upstream data in chain mode, and the choice of busy bit from pin levels. The bench also covers ending a frame early and ignoring a change of the parallel result during a frame.

// File: rtl/adcp_pkg.sv
package adcp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAIT,
    ST_SHIFT,
    ST_OFF
  } port_state_e;
endpackage

// File: rtl/adcp_sync.sv
module adcp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] flop_q;
    always_ff @(posedge clk) begin
      if (rst) flop_q <= '0;
      else     flop_q <= {flop_q[STAGES-2:0], d_async[b]};
    end
    assign d_sync[b] = flop_q[STAGES-1];
  end
endmodule

// File: rtl/adcp_timer.sv
module adcp_timer #(
  parameter int CONV_CYC = 71
) (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  output logic start_ok,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CONV_CYC + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(CONV_CYC);
  localparam logic [CW-1:0] ONE      = CW'(1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign start_ok = start_req && !busy_q;
  assign done     = busy_q && (cnt_q == ONE);
  assign busy     = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_ok) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD_VAL;
    end else if (busy_q) begin
      if (cnt_q == ONE) busy_q <= 1'b0;
      cnt_q <= cnt_q - ONE;
    end
  end

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    busy_q && (cnt_q != ONE) |=> busy_q); // R4
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    busy_q && start_req |=> (cnt_q == $past(cnt_q) - ONE)); // R4
endmodule

// File: rtl/adcp_shift.sv
module adcp_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         load_lead,
  input  logic         shift_en,
  input  logic         din,
  output logic         msb,
  output logic         lead
);
  logic [W-1:0] sr_q;
  logic         lead_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      lead_q <= 1'b0;
    end else if (load) begin
      sr_q   <= load_val;
      lead_q <= load_lead;
    end else if (shift_en) begin
      if (lead_q) lead_q <= 1'b0;
      else        sr_q   <= {sr_q[W-2:0], din};
    end
  end

  assign msb  = sr_q[W-1];
  assign lead = lead_q;

  AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (rst)
    shift_en && !lead_q && !load |=> sr_q[W-1] == $past(sr_q[W-2])); // R5
  AST_CHAIN_FEED: assert property (@(posedge clk) disable iff (rst)
    shift_en && !lead_q && !load |=> sr_q[0] == $past(din)); // R8
  AST_LEAD_FIRST: assert property (@(posedge clk) disable iff (rst)
    shift_en && lead_q && !load |=> $stable(sr_q) && !lead_q); // R3
endmodule

// File: rtl/ser_adc_port.sv
module ser_adc_port
  import adcp_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYC    = 71,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_start,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic [DATA_W-1:0] conv_result,
  output logic              ser_dout,
  output logic              ser_dout_oe,
  output logic              busy
);
  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] LIM_PLAIN = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LIM_LEAD  = CNT_W'(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

  logic [2:0] pins_s;
  logic       start_s, sclk_s, din_s;
  logic       start_prev_q, sclk_prev_q;
  logic       start_rise, sclk_fall;

  adcp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async ({conv_start, ser_clk, ser_din}),
    .d_sync  (pins_s)
  );

  assign start_s = pins_s[2];
  assign sclk_s  = pins_s[1];
  assign din_s   = pins_s[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      start_prev_q <= 1'b0;
      sclk_prev_q  <= 1'b0;
    end else begin
      start_prev_q <= start_s;
      sclk_prev_q  <= sclk_s;
    end
  end

  assign start_rise = start_s && !start_prev_q;
  assign sclk_fall  = !sclk_s && sclk_prev_q;

  logic start_ok, busy_q, conv_done;

  adcp_timer #(.CONV_CYC(CONV_CYC)) i_timer (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_rise),
    .start_ok  (start_ok),
    .busy      (busy_q),
    .done      (conv_done)
  );

  assign busy = busy_q;

  port_state_e      state_q, state_d;
  logic             mode_chain_q, mode_chain_d;
  logic             busy_opt_q, busy_opt_d;
  logic             lead_used_q, lead_used_d;
  logic [CNT_W-1:0] fall_cnt_q, fall_cnt_d;
  logic             load, load_lead, shift_en;
  logic             sr_msb, sr_lead;
  logic             en_act;
  logic [CNT_W-1:0] limit;

  adcp_shift #(.W(DATA_W)) i_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_val  (conv_result),
    .load_lead (load_lead),
    .shift_en  (shift_en),
    .din       (din_s),
    .msb       (sr_msb),
    .lead      (sr_lead)
  );

  assign en_act = !start_s || !din_s;
  assign limit  = lead_used_q ? LIM_LEAD : LIM_PLAIN;

  always_comb begin
    state_d      = state_q;
    mode_chain_d = mode_chain_q;
    busy_opt_d   = busy_opt_q;
    lead_used_d  = lead_used_q;
    fall_cnt_d   = fall_cnt_q;
    load         = 1'b0;
    load_lead    = 1'b0;
    shift_en     = 1'b0;
    if (start_ok) begin
      state_d      = ST_CONV;
      mode_chain_d = !din_s;
      busy_opt_d   = sclk_s;
      fall_cnt_d   = '0;
    end else begin
      case (state_q)
        ST_CONV: begin
          if (conv_done) begin
            load       = 1'b1;
            fall_cnt_d = '0;
            if (mode_chain_q) begin
              load_lead = busy_opt_q;
              state_d   = ST_SHIFT;
            end else if (en_act) begin
              load_lead = 1'b1;
              state_d   = ST_SHIFT;
            end else begin
              state_d = ST_WAIT;
            end
            lead_used_d = load_lead;
          end
        end
        ST_WAIT: begin
          if (en_act) state_d = ST_SHIFT;
        end
        ST_SHIFT: begin
          if (mode_chain_q) begin
            shift_en = sclk_fall;
          end else if (!en_act) begin
            state_d = ST_OFF;
          end else if (sclk_fall) begin
            shift_en   = 1'b1;
            fall_cnt_d = fall_cnt_q + CNT_ONE;
            if (fall_cnt_d == limit) state_d = ST_OFF;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      mode_chain_q <= 1'b0;
      busy_opt_q   <= 1'b0;
      lead_used_q  <= 1'b0;
      fall_cnt_q   <= '0;
    end else begin
      state_q      <= state_d;
      mode_chain_q <= mode_chain_d;
      busy_opt_q   <= busy_opt_d;
      lead_used_q  <= lead_used_d;
      fall_cnt_q   <= fall_cnt_d;
    end
  end

  logic sdo_d, oe_d, sdo_q, oe_q;

  always_comb begin
    sdo_d = 1'b0;
    oe_d  = 1'b0;
    if (state_q == ST_SHIFT) begin
      oe_d  = 1'b1;
      sdo_d = sr_lead ? (mode_chain_q && din_s) : sr_msb;
    end else if (mode_chain_q && (state_q == ST_CONV) && !start_s && !din_s) begin
      oe_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      sdo_q <= sdo_d;
      oe_q  <= oe_d;
    end
  end

  assign ser_dout    = sdo_q;
  assign ser_dout_oe = oe_q;

  AST_SELECT_HIZ: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) && !mode_chain_q |=> !oe_q); // R4
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    busy_q && $past(busy_q) |-> $stable(mode_chain_q)); // R1
  AST_FRAME_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SHIFT) && !mode_chain_q |-> fall_cnt_q < limit); // R6
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OFF) && !start_ok |=> !oe_q); // R6
  AST_CHAIN_LOW: assert property (@(posedge clk) disable iff (rst)
    mode_chain_q && (state_q == ST_CONV) && !start_s && !din_s |=> oe_q && !sdo_q); // R7
endmodule

// File: tb/test_ser_adc_port.sv
module test_ser_adc_port;
  localparam int DATA_W   = 16;
  localparam int CONV_CYC = 71;
  localparam int HALF     = 6;
  localparam int SETTLE   = 8;
  localparam int NVEC     = 7;

  // mode: 0 select/strobe enable, 1 select/data-in enable, 2 select with busy bit,
  //       3 chain, 4 chain with busy bit
  localparam logic [18:0] VECS [NVEC] = '{
    {3'd0, 16'hA5C3},
    {3'd1, 16'h3C96},
    {3'd2, 16'hF00D},
    {3'd3, 16'h8421},
    {3'd4, 16'h5AA5},
    {3'd0, 16'hFFFF},
    {3'd2, 16'h0001}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic conv_start = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_din = 1'b0;
  logic [DATA_W-1:0] conv_result = '0;
  logic ser_dout, ser_dout_oe, busy;

  int n_chk = 0;
  int n_err = 0;
  int bcount = 0;
  logic clr_bc = 1'b1;

  always #5 clk = ~clk;

  ser_adc_port #(.DATA_W(DATA_W), .CONV_CYC(CONV_CYC), .SYNC_STAGES(2)) i_ser_adc_port (
    .clk         (clk),
    .rst         (rst),
    .conv_start  (conv_start),
    .ser_clk     (ser_clk),
    .ser_din     (ser_din),
    .conv_result (conv_result),
    .ser_dout    (ser_dout),
    .ser_dout_oe (ser_dout_oe),
    .busy        (busy)
  );

  always @(negedge clk) begin
    if (clr_bc) bcount <= 0;
    else if (busy) bcount <= bcount + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic look;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse;
    tick(1);
    ser_clk = 1'b1;
    tick(HALF);
    ser_clk = 1'b0;
    tick(SETTLE);
  endtask

  task automatic start_conv(input logic din_lvl, input logic clk_lvl);
    conv_start = 1'b0;
    ser_din = din_lvl;
    ser_clk = clk_lvl;
    tick(SETTLE);
    conv_start = 1'b1;
    tick(SETTLE);
  endtask

  task automatic wait_conv;
    tick(CONV_CYC + SETTLE);
  endtask

  task automatic read_bits(input int n, input logic [31:0] exp_bits,
                           input logic [31:0] feed, input bit do_feed, input string req);
    for (int i = 0; i < n; i++) begin
      look;
      check(req, {30'd0, ser_dout_oe, ser_dout}, {30'd0, 1'b1, exp_bits[n-1-i]});
      if (do_feed) ser_din = feed[n-1-i];
      pulse;
    end
  endtask

  task automatic run_case(input logic [2:0] mode, input logic [15:0] val);
    conv_result = val;
    case (mode)
      3'd0: begin
        start_conv(1'b1, 1'b0);
        look; check("R4 busy during conversion", {31'd0, busy}, 32'd1);
        wait_conv;
        conv_result = ~val; // R10: late change must not reach the frame
        look; check("R5 floated before enable", {31'd0, ser_dout_oe}, 32'd0);
        conv_start = 1'b0;
        tick(SETTLE);
        read_bits(16, {16'd0, val}, 32'd0, 1'b0, "R5/R10");
        look; check("R6 end after 16 edges", {31'd0, ser_dout_oe}, 32'd0);
      end
      3'd1: begin
        start_conv(1'b1, 1'b0);
        look; check("R4 select floated in conversion", {31'd0, ser_dout_oe}, 32'd0);
        pulse; // R11: edge during conversion ignored
        wait_conv;
        conv_result = ~val;
        ser_din = 1'b0;
        tick(SETTLE);
        read_bits(16, {16'd0, val}, 32'd0, 1'b0, "R5/R11");
        look; check("R6 end after 16 edges", {31'd0, ser_dout_oe}, 32'd0);
        ser_din = 1'b1;
      end
      3'd2: begin
        start_conv(1'b1, 1'b0);
        conv_start = 1'b0;
        wait_conv;
        conv_result = ~val;
        read_bits(17, {16'd0, val}, 32'd0, 1'b0, "R3");
        look; check("R3 end after 17 edges", {31'd0, ser_dout_oe}, 32'd0);
      end
      3'd3: begin
        start_conv(1'b0, 1'b0);
        look; check("R4 chain floated with strobe high", {31'd0, ser_dout_oe}, 32'd0);
        wait_conv;
        conv_result = ~val;
        read_bits(32, {val, ~val}, {~val, 16'd0}, 1'b1, "R8/R7/R2");
      end
      default: begin
        start_conv(1'b0, 1'b1);
        ser_clk = 1'b0; // R11: falling edge during conversion
        wait_conv;
        conv_result = ~val;
        look; check("R9 lead follows low input", {30'd0, ser_dout_oe, ser_dout}, 32'd2);
        ser_din = 1'b1;
        tick(SETTLE);
        read_bits(17, {15'd0, 1'b1, val}, 32'd0, 1'b1, "R9/R2");
      end
    endcase
  endtask

  initial begin
    #2_000_000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    tick(4);
    look;
    check("R12 reset outputs", {29'd0, busy, ser_dout_oe, ser_dout}, 32'd0);
    rst = 1'b0;
    tick(SETTLE);

    for (int k = 0; k < NVEC; k++) begin
      run_case(VECS[k][18:16], VECS[k][15:0]);
    end

    // R7 and R4: chain drive-low, retrigger ignored, exact busy length
    conv_result = 16'h8001;
    conv_start = 1'b0;
    ser_din = 1'b0;
    ser_clk = 1'b0;
    tick(SETTLE);
    clr_bc = 1'b0;
    conv_start = 1'b1;
    tick(SETTLE);
    conv_start = 1'b0;
    tick(SETTLE);
    look; check("R7 driven low in conversion", {30'd0, ser_dout_oe, ser_dout}, 32'd2);
    conv_start = 1'b1;
    tick(SETTLE);
    look; check("R4 retrigger floats chain", {31'd0, ser_dout_oe}, 32'd0);
    tick(CONV_CYC + SETTLE);
    look; check("R4 busy length", bcount, CONV_CYC);
    check("R7 MSB at end", {30'd0, ser_dout_oe, ser_dout}, 32'd3);
    clr_bc = 1'b1;

    // R6: early end by enable going high, stays floated
    conv_result = 16'hF0F0;
    start_conv(1'b1, 1'b0);
    wait_conv;
    ser_din = 1'b0;
    tick(SETTLE);
    read_bits(3, 32'h7, 32'd0, 1'b0, "R6 prefix");
    ser_din = 1'b1;
    tick(SETTLE);
    look; check("R6 enable high floats", {31'd0, ser_dout_oe}, 32'd0);
    ser_din = 1'b0;
    tick(SETTLE);
    look; check("R6 stays floated", {31'd0, ser_dout_oe}, 32'd0);
    ser_din = 1'b1;
    tick(SETTLE);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule